// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block turns the three Hall-effect rotor position bits of a brushless motor into six gate-driver enables for a three-phase bridge, three high-side (top) switches and three low-side (bottom) switches. Each rotor position selects one top and one bottom switch on different phases. The step order can be reversed, the sensors can be mounted at either of two electrical spacings, and a second mode drives a four-phase motor from two sensors.

A synchroniser and a short majority-vote filter clean the raw sensor inputs. Several overrides sit on top of the commutation table, in a fixed priority order: braking (unconditional or chopped by the PWM gate), PWM gating of both rails or of the bottom rail only, overcurrent cut-off, output blanking on a direction reversal, and a power gate from the enable and undervoltage inputs. A fault flag reports the conditions under which the motor cannot be driven normally. Driver enables are registered. The top-rail polarity is applied after the register so that the off level is correct from reset onwards.

Top module: `hall_commutator`

## Requirements
- R1: With `spacing60_i`=0, `four_phase_i`=0 and `fwd_i`=1, the sensor code {S3,S2,S1} = `hall_i[2:0]` steps forward through 001, 011, 010, 110, 100, 101 (steps 0 to 5). In step s the top switch of phase s/2 is on, and the bottom switch of phase ((s+1)/2+1) mod 3 is on (integer division). Bit k of `top_o`/`bot_o` is phase k.
- R2: With `spacing60_i`=1 the code is read with S2 inverted before the R1 table is applied. Codes 000 and 111 are invalid at 120-degree spacing, and 010 and 101 are invalid at 60-degree spacing. An invalid code turns all six drivers off and sets `fault_o`.
- R3: With `fwd_i`=0 the step used is (s+3) mod 6. Outside braking, at most one bottom driver is on.
- R4: When `fwd_i` differs from its value at the previous clock edge, all drivers are off in the two output cycles that follow. Driving resumes in the third cycle. Blanking alone does not set `fault_o`.
- R5: With power present, `brake_i`=1 overrides the sensors, blanking, PWM mode and overcurrent. All top drivers go off. The bottom drivers are all on when `brake_hard_i`=1, and all follow `pwm_i` when it is 0.
- R6: When `pwm_i`=0, the bottom drivers are off. The top drivers are also off unless `pwm_bottom_only_i`=1.
- R7: `top_active_high_i`=1 makes a top line high when its switch is on. When it is 0, the three top lines are inverted, including their off level. This takes effect in the same cycle. Bottom lines are always active high.
- R8: `enable_i`=0 or `undervolt_i`=1 turns every driver off, overriding brake, and sets `fault_o`.
- R9: `overcurrent_i`=1 sets `fault_o`. With `OC_ALL_OFF`=1 it turns all drivers off. With `OC_ALL_OFF`=0 it turns off only the bottom drivers, and the top drivers keep their commutation value.
- R10: With `four_phase_i`=1 only S1=`hall_i[0]` and S2=`hall_i[1]` are used, and every code is valid. The index is i={S2, S2^S1}, and it becomes (i+2) mod 4 in reverse. The top driver on is phase 0 for i<2 and phase 2 otherwise. The bottom driver on is phase 0 for i in {0,3} and phase 2 otherwise. Phase 1 stays off, under brake as well.
- R11: Each sensor bit passes through two synchroniser flops and a vote over its last three samples. A sensor change shows at the outputs after the fifth clock edge. A one-cycle sensor glitch does not change the outputs.
- R12: During reset and until the first edge after it, all drivers are off (top lines at their inactive level) and `fault_o`=1. Control inputs other than the sensors act at the first clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Raw sensor bits {S3,S2,S1} |
| fwd_i | input | 1 | 1 forward, 0 reverse |
| spacing60_i | input | 1 | 1 selects 60-degree, 0 selects 120-degree sensor spacing |
| four_phase_i | input | 1 | 1 selects four-phase two-sensor mode |
| brake_i | input | 1 | Brake request |
| brake_hard_i | input | 1 | 1 unconditional brake, 0 PWM-chopped brake |
| pwm_bottom_only_i | input | 1 | 1 gates only the bottom rail with PWM |
| top_active_high_i | input | 1 | Active level of the top lines |
| enable_i | input | 1 | Driver enable |
| overcurrent_i | input | 1 | Overcurrent flag |
| pwm_i | input | 1 | PWM gate |
| undervolt_i | input | 1 | Supply undervoltage flag |
| top_o | output | 3 | Top driver lines, phase k on bit k |
| bot_o | output | 3 | Bottom driver lines, active high |
| fault_o | output | 1 | Fault flag |

## Verification
Control inputs are registered once, so their effect is due one edge after they are applied. Sensor changes pass through two synchroniser flops, two vote samples and the output register, so they are due after the fifth edge. Polarity is combinational. The bench drives on falling edges and, for sweeps, waits eight cycles before sampling. For the latency, reversal-blanking and glitch cases it samples on each falling edge and compares against the exact cycle each requirement names.

// File: rtl/hall_commut_pkg.sv
package hall_commut_pkg;

    localparam int PHASES = 3;

    typedef logic [PHASES-1:0] phase_vec_t;

    // One decoded commutation step before any override.
    typedef struct packed {
        phase_vec_t top_on;
        phase_vec_t bot_on;
        logic       valid;
    } step_drive_t;

endpackage

// File: rtl/hall_input_filter.sv
module hall_input_filter #(
    parameter int WIDTH       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] clean_o
);

    localparam int VOTE_MIN = VOTE_TAPS / 2 + 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [SYNC_STAGES-1:0] sync_d, sync_q;
        logic [VOTE_TAPS-1:0]   hist_d, hist_q;

        always_comb begin
            sync_d = {sync_q[SYNC_STAGES-2:0], raw_i[b]};
            hist_d = {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
                hist_q <= '0;
            end else begin
                sync_q <= sync_d;
                hist_q <= hist_d;
            end
        end

        assign clean_o[b] = ($countones(hist_q) >= VOTE_MIN);
    end

endmodule

// File: rtl/commut_step_decoder.sv
module commut_step_decoder
    import hall_commut_pkg::*;
(
    input  logic [PHASES-1:0] code_i,
    input  logic              spacing60_i,
    input  logic              four_phase_i,
    input  logic              fwd_i,
    output step_drive_t       drive_o
);

    logic [2:0] norm_code;
    logic [2:0] step;
    logic [1:0] quad;

    always_comb begin
        drive_o   = '0;
        step      = '0;
        quad      = '0;
        norm_code = spacing60_i ? (code_i ^ 3'b010) : code_i;

        if (four_phase_i) begin
            quad = {code_i[1], code_i[1] ^ code_i[0]};
            if (!fwd_i) begin
                quad = quad + 2'd2;
            end
            drive_o.valid  = 1'b1;
            drive_o.top_on = quad[1] ? 3'b100 : 3'b001;
            drive_o.bot_on = (quad[1] ^ quad[0]) ? 3'b100 : 3'b001;
        end else begin
            drive_o.valid = 1'b1;
            case (norm_code)
                3'b001:  step = 3'd0;
                3'b011:  step = 3'd1;
                3'b010:  step = 3'd2;
                3'b110:  step = 3'd3;
                3'b100:  step = 3'd4;
                3'b101:  step = 3'd5;
                default: drive_o.valid = 1'b0;
            endcase
            if (!fwd_i) begin
                step = (step >= 3'd3) ? step - 3'd3 : step + 3'd3;
            end
            if (drive_o.valid) begin
                case (step)
                    3'd0:    begin drive_o.top_on = 3'b001; drive_o.bot_on = 3'b010; end
                    3'd1:    begin drive_o.top_on = 3'b001; drive_o.bot_on = 3'b100; end
                    3'd2:    begin drive_o.top_on = 3'b010; drive_o.bot_on = 3'b100; end
                    3'd3:    begin drive_o.top_on = 3'b010; drive_o.bot_on = 3'b001; end
                    3'd4:    begin drive_o.top_on = 3'b100; drive_o.bot_on = 3'b001; end
                    default: begin drive_o.top_on = 3'b100; drive_o.bot_on = 3'b010; end
                endcase
            end
        end
    end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_commut_pkg::*;
#(
    parameter bit OC_ALL_OFF   = 1'b1,
    parameter int BLANK_CYCLES = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int VOTE_TAPS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] hall_i,
    input  logic              fwd_i,
    input  logic              spacing60_i,
    input  logic              four_phase_i,
    input  logic              brake_i,
    input  logic              brake_hard_i,
    input  logic              pwm_bottom_only_i,
    input  logic              top_active_high_i,
    input  logic              enable_i,
    input  logic              overcurrent_i,
    input  logic              pwm_i,
    input  logic              undervolt_i,
    output logic [PHASES-1:0] top_o,
    output logic [PHASES-1:0] bot_o,
    output logic              fault_o
);

    localparam int               CNT_W      = $clog2(BLANK_CYCLES + 1);
    localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_CYCLES - 1);

    typedef struct packed {
        logic             fwd;
        logic [CNT_W-1:0] blank_cnt;
        phase_vec_t       top_on;
        phase_vec_t       bot_on;
        logic             fault;
    } ctrl_state_t;

    localparam ctrl_state_t RESET_STATE = '{
        fwd:       1'b1,
        blank_cnt: '0,
        top_on:    '0,
        bot_on:    '0,
        fault:     1'b1
    };

    logic [PHASES-1:0] hall_clean;
    step_drive_t       step_drive;
    ctrl_state_t       st_d, st_q;

    logic       reversal;
    logic       blanking;
    logic       powered;
    phase_vec_t top_n;
    phase_vec_t bot_n;

    hall_input_filter #(
        .WIDTH      (PHASES),
        .SYNC_STAGES(SYNC_STAGES),
        .VOTE_TAPS  (VOTE_TAPS)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (hall_i),
        .clean_o(hall_clean)
    );

    commut_step_decoder u_decoder (
        .code_i      (hall_clean),
        .spacing60_i (spacing60_i),
        .four_phase_i(four_phase_i),
        .fwd_i       (fwd_i),
        .drive_o     (step_drive)
    );

    always_comb begin
        st_d     = st_q;
        reversal = (fwd_i != st_q.fwd);
        blanking = reversal || (st_q.blank_cnt != '0);
        powered  = enable_i && !undervolt_i;

        st_d.fwd = fwd_i;
        if (reversal) begin
            st_d.blank_cnt = BLANK_LOAD;
        end else if (st_q.blank_cnt != '0) begin
            st_d.blank_cnt = st_q.blank_cnt - 1'b1;
        end

        top_n = step_drive.top_on;
        bot_n = step_drive.bot_on;

        if (!pwm_i) begin
            bot_n = '0;
            if (!pwm_bottom_only_i) begin
                top_n = '0;
            end
        end
        if (overcurrent_i) begin
            bot_n = '0;
            if (OC_ALL_OFF) begin
                top_n = '0;
            end
        end
        if (!step_drive.valid || blanking) begin
            top_n = '0;
            bot_n = '0;
        end
        if (brake_i) begin
            top_n = '0;
            bot_n = brake_hard_i ? '1 : {PHASES{pwm_i}};
        end
        if (four_phase_i) begin
            top_n[1] = 1'b0;
            bot_n[1] = 1'b0;
        end
        if (!powered) begin
            top_n = '0;
            bot_n = '0;
        end

        st_d.top_on = top_n;
        st_d.bot_on = bot_n;
        st_d.fault  = !powered || overcurrent_i || !step_drive.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_o   = st_q.top_on ^ {PHASES{!top_active_high_i}};
    assign bot_o   = st_q.bot_on;
    assign fault_o = st_q.fault;

endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk #(
    parameter bit OC_ALL_OFF = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_i,
    input logic       brake_i,
    input logic       brake_hard_i,
    input logic       top_active_high_i,
    input logic       enable_i,
    input logic       overcurrent_i,
    input logic       undervolt_i,
    input logic [2:0] top_o,
    input logic [2:0] bot_o,
    input logic       fault_o
);

    AST_BRAKE_TOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !undervolt_i && brake_i) |=> (top_o == {3{!top_active_high_i}})); // R5

    AST_BRAKE_HARD_BOTTOM_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !undervolt_i && brake_i && brake_hard_i) |=> (bot_o[0] && bot_o[2])); // R5

    AST_POWER_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || undervolt_i) |=> (bot_o == 3'b000 && top_o == {3{!top_active_high_i}} && fault_o)); // R8

    AST_SINGLE_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_i |=> $onehot0(bot_o)); // R3

    AST_REVERSAL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (fwd_i != $past(fwd_i)) && !brake_i) |=> (bot_o == 3'b000)); // R4

    AST_OVERCURRENT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (overcurrent_i && !brake_i) |=> (bot_o == 3'b000 && fault_o)); // R9

endmodule

bind hall_commutator hall_commutator_chk #(.OC_ALL_OFF(OC_ALL_OFF)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fwd_i            (fwd_i),
    .brake_i          (brake_i),
    .brake_hard_i     (brake_hard_i),
    .top_active_high_i(top_active_high_i),
    .enable_i         (enable_i),
    .overcurrent_i    (overcurrent_i),
    .undervolt_i      (undervolt_i),
    .top_o            (top_o),
    .bot_o            (bot_o),
    .fault_o          (fault_o)
);

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b001;
    logic       fwd_i = 1'b1;
    logic       spacing60_i = 1'b0;
    logic       four_phase_i = 1'b0;
    logic       brake_i = 1'b0;
    logic       brake_hard_i = 1'b0;
    logic       pwm_bottom_only_i = 1'b0;
    logic       top_active_high_i = 1'b1;
    logic       enable_i = 1'b1;
    logic       overcurrent_i = 1'b0;
    logic       pwm_i = 1'b1;
    logic       undervolt_i = 1'b0;

    logic [2:0] top_a, bot_a, top_b, bot_b;
    logic       fault_a, fault_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hall_commutator #(.OC_ALL_OFF(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .fwd_i(fwd_i),
        .spacing60_i(spacing60_i), .four_phase_i(four_phase_i),
        .brake_i(brake_i), .brake_hard_i(brake_hard_i),
        .pwm_bottom_only_i(pwm_bottom_only_i), .top_active_high_i(top_active_high_i),
        .enable_i(enable_i), .overcurrent_i(overcurrent_i), .pwm_i(pwm_i),
        .undervolt_i(undervolt_i), .top_o(top_a), .bot_o(bot_a), .fault_o(fault_a)
    );

    hall_commutator #(.OC_ALL_OFF(1'b0)) u_dut_topkeep (
        .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .fwd_i(fwd_i),
        .spacing60_i(spacing60_i), .four_phase_i(four_phase_i),
        .brake_i(brake_i), .brake_hard_i(brake_hard_i),
        .pwm_bottom_only_i(pwm_bottom_only_i), .top_active_high_i(top_active_high_i),
        .enable_i(enable_i), .overcurrent_i(overcurrent_i), .pwm_i(pwm_i),
        .undervolt_i(undervolt_i), .top_o(top_b), .bot_o(bot_b), .fault_o(fault_b)
    );

    // Forward order of 120-degree codes (R1).
    function automatic logic [2:0] seq120(input int idx);
        case (idx)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b010;
            3: return 3'b110;
            4: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    // Expected {fault, top lines, bottom lines} for steady inputs.
    function automatic logic [6:0] model(input bit oc_all);
        logic [2:0] t, b, c;
        logic ok;
        int s, tp, bp, q;
        t = '0; b = '0; ok = 1'b1;
        if (four_phase_i) begin
            q = {hall_i[1], hall_i[1] ^ hall_i[0]};
            if (!fwd_i) q = (q + 2) % 4;
            t = (q < 2) ? 3'b001 : 3'b100;
            b = (q == 0 || q == 3) ? 3'b001 : 3'b100;
        end else begin
            c = spacing60_i ? (hall_i ^ 3'b010) : hall_i;
            s = -1;
            for (int i = 0; i < 6; i++) if (seq120(i) == c) s = i;
            ok = (s >= 0);
            if (ok) begin
                if (!fwd_i) s = (s + 3) % 6;
                tp = s / 2;
                bp = ((s + 1) / 2 + 1) % 3;
                t = 3'(1 << tp);
                b = 3'(1 << bp);
            end
        end
        if (!pwm_i) begin b = '0; if (!pwm_bottom_only_i) t = '0; end
        if (overcurrent_i) begin b = '0; if (oc_all) t = '0; end
        if (!ok) begin t = '0; b = '0; end
        if (brake_i) begin t = '0; b = brake_hard_i ? 3'b111 : {3{pwm_i}}; end
        if (four_phase_i) begin t[1] = 1'b0; b[1] = 1'b0; end
        if (!enable_i || undervolt_i) begin t = '0; b = '0; end
        return {(!enable_i || undervolt_i || overcurrent_i || !ok),
                (top_active_high_i ? t : ~t), b};
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got fault/top/bot=%b expected %b (hall=%b fwd=%b)",
                     req, act, exp, hall_i, fwd_i);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check_both(input string req);
        check(req, {fault_a, top_a, bot_a}, model(1'b1));
        check(req, {fault_b, top_b, bot_b}, model(1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [6:0] held;
        string tag;

        // R12: reset state, with both top polarities
        repeat (3) @(negedge clk);
        check("R12", {fault_a, top_a, bot_a}, 7'b1_000_000);
        top_active_high_i = 1'b0;
        #1;
        check("R12", {fault_a, top_a, bot_a}, 7'b1_111_000);
        top_active_high_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 R2 R3 R7: sweep spacing, direction, polarity, code
        for (int sp = 0; sp < 2; sp++)
            for (int fw = 0; fw < 2; fw++)
                for (int pol = 0; pol < 2; pol++)
                    for (int cd = 0; cd < 8; cd++) begin
                        spacing60_i = sp[0];
                        fwd_i = fw[0];
                        top_active_high_i = pol[0];
                        hall_i = cd[2:0];
                        settle();
                        if ((sp == 0 && (cd == 0 || cd == 7)) || (sp == 1 && (cd == 2 || cd == 5)))
                            tag = "R2 invalid code";
                        else if (pol == 0) tag = "R7 polarity";
                        else if (fw == 0) tag = "R3 reverse";
                        else if (sp == 1) tag = "R2 spacing60";
                        else tag = "R1 forward";
                        check(tag, {fault_a, top_a, bot_a}, model(1'b1));
                    end
        spacing60_i = 1'b0; fwd_i = 1'b1; top_active_high_i = 1'b1;

        // R6: PWM gating in both modes
        hall_i = 3'b011;
        settle();
        for (int m = 0; m < 2; m++) begin
            pwm_bottom_only_i = m[0];
            pwm_i = 1'b0;
            @(negedge clk);
            check("R6 pwm low", {fault_a, top_a, bot_a}, model(1'b1));
            pwm_i = 1'b1;
            @(negedge clk);
            check("R6 pwm high", {fault_a, top_a, bot_a}, model(1'b1));
        end
        pwm_bottom_only_i = 1'b0;

        // R5: brake modes, over invalid code and overcurrent too
        for (int h = 0; h < 2; h++)
            for (int p = 0; p < 2; p++) begin
                brake_i = 1'b1; brake_hard_i = h[0]; pwm_i = p[0];
                @(negedge clk);
                check_both("R5 brake");
            end
        pwm_i = 1'b1; brake_hard_i = 1'b1;
        hall_i = 3'b111;
        settle();
        check("R5 brake over invalid", {fault_a, top_a, bot_a}, 7'b1_000_111);
        overcurrent_i = 1'b1; top_active_high_i = 1'b0;
        @(negedge clk);
        check("R5 brake over overcurrent", {fault_a, top_a, bot_a}, 7'b1_111_111);
        overcurrent_i = 1'b0; top_active_high_i = 1'b1;
        hall_i = 3'b011;
        settle();

        // R8: power gate overrides brake
        enable_i = 1'b0;
        @(negedge clk);
        check("R8 enable low", {fault_a, top_a, bot_a}, 7'b1_000_000);
        enable_i = 1'b1; undervolt_i = 1'b1;
        @(negedge clk);
        check("R8 undervolt", {fault_a, top_a, bot_a}, 7'b1_000_000);
        undervolt_i = 1'b0; brake_i = 1'b0;
        @(negedge clk);
        check("R8 recovered", {fault_a, top_a, bot_a}, model(1'b1));

        // R9: overcurrent variants
        for (int cd = 1; cd < 7; cd++) begin
            hall_i = cd[2:0];
            settle();
            overcurrent_i = 1'b1;
            @(negedge clk);
            check_both("R9 overcurrent");
            overcurrent_i = 1'b0;
        end

        // R10: four-phase, S3 tied to S2
        four_phase_i = 1'b1;
        for (int fw = 0; fw < 2; fw++)
            for (int cd = 0; cd < 4; cd++) begin
                fwd_i = fw[0];
                hall_i = {cd[1], cd[1], cd[0]};
                settle();
                check("R10 four-phase", {fault_a, top_a, bot_a}, model(1'b1));
            end
        brake_i = 1'b1; brake_hard_i = 1'b1;
        @(negedge clk);
        check("R10 four-phase brake", {fault_a, top_a, bot_a}, 7'b0_000_101);
        brake_i = 1'b0; four_phase_i = 1'b0; fwd_i = 1'b1;

        // R4: reversal blanking timing
        hall_i = 3'b001;
        settle();
        fwd_i = 1'b0;
        @(negedge clk);
        check("R4 blank cycle 1", {fault_a, top_a, bot_a}, 7'b0_000_000);
        @(negedge clk);
        check("R4 blank cycle 2", {fault_a, top_a, bot_a}, 7'b0_000_000);
        @(negedge clk);
        check("R4 resumed", {fault_a, top_a, bot_a}, model(1'b1));
        fwd_i = 1'b1;
        settle();

        // R11: sensor latency of five edges
        held = model(1'b1);
        hall_i = 3'b011;
        repeat (4) @(negedge clk);
        check("R11 before fifth edge", {fault_a, top_a, bot_a}, held);
        @(negedge clk);
        check("R11 after fifth edge", {fault_a, top_a, bot_a}, model(1'b1));
        settle();

        // R11: one-cycle glitch rejected
        held = model(1'b1);
        hall_i = 3'b001;
        @(negedge clk);
        hall_i = 3'b011;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R11 glitch", {fault_a, top_a, bot_a}, held);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule